// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Minimum Unit

This block returns the unsigned minimum of two operand words, where the word is carved into lanes at runtime. The word is made of four equal base sections. A three-bit partition mask holds one bit per internal section boundary and decides whether the sections on either side of that boundary stay separate or join into one wider lane. Every layout the mask can express is legal. This includes four byte lanes, one full-width lane, and uneven mixes such as a 24-bit lane next to an 8-bit lane.

One shared set of per-section comparators feeds a compare chain. The chain is cut at each isolated boundary and carried across each joined one. A single mask therefore reuses the same gates for every SIMD layout, and the logic is not copied once per layout. Each output section takes either the x section or the y section, according to the decision of the lane it belongs to.

The minimum is available combinationally on `min_o`, so a change of mask or operands shows up in the same cycle. A registered copy, `min_q`, is provided for callers that want a flopped result. It is cleared by a synchronous active-high reset.

Top module: `pmin_unit`

## Requirements
- R1: The word of W bits (default 32) is split into four sections of W/4 bits, with section 0 in the least significant bits. Mask bit j sits on the boundary between section j and section j+1. A value of 1 isolates the two sections, and a value of 0 joins them into one lane.
- R2: When a section is isolated on both sides, its output section is the unsigned minimum of the x and y section values.
- R3: In a lane of joined sections, the lane's output is the unsigned minimum of the whole lane values. The most significant section of the lane decides, unless its x and y values are equal, in which case the next lower section of the same lane decides.
- R4: All eight mask values are legal. Each produces, lane by lane, the minimum of the lanes that the mask defines, including the uneven layouts 24+8, 8+24, 16+8+8 and 8+8+16.
- R5: When the x and y values of a lane are equal, the lane's output equals that common value. In particular, when x equals y, the output equals x.
- R6: `min_o` is combinational. It reflects a new mask or new operands in the same cycle they are applied, with no clock edge needed.
- R7: On every rising clock edge, `min_q` takes the value of `min_o`. While `rst` is high at a rising edge, `min_q` becomes 0.
- R8: Each output section equals either the x or the y value of the same section position. No value moves between sections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered result |
| rst | input | 1 | Synchronous active-high reset of `min_q` |
| mask_i | input | 3 | Partition mask, bit j on the boundary above section j, 1 = cut |
| x_i | input | W | First operand |
| y_i | input | W | Second operand |
| min_o | output | W | Combinational per-lane minimum |
| min_q | output | W | Registered copy of `min_o` |

## Verification
Two things can land in the same cycle: a change of partition mask and a change of operands. The new layout must take effect together with the new data, and no stale lane boundary may leak into the result. The bench provokes this by changing the mask and both operands at the same falling edge, sweeping all eight masks with random data and with edge operands (zero, all ones, equal values). It judges `min_o` shortly after the change, and `min_q` after the following rising edge, against a lane-splitting reference model computed in the bench.

// File: rtl/pmin_pkg.sv
package pmin_pkg;
  localparam int NSEC = 4;
  localparam int NBND = NSEC - 1;
  typedef logic [NBND-1:0] pmask_t;
endpackage

// File: rtl/pmin_sec_cmp.sv
module pmin_sec_cmp #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] xs_i,
  input  logic [SW-1:0] ys_i,
  output logic          lt_o,
  output logic          eq_o
);
  always_comb begin
    lt_o = (xs_i < ys_i);
    eq_o = (xs_i == ys_i);
  end
endmodule

// File: rtl/pmin_chain.sv
module pmin_chain
  import pmin_pkg::*;
(
  input  logic [NSEC-1:0] lt_i,
  input  logic [NSEC-1:0] eq_i,
  input  pmask_t          mask_i,
  output logic [NSEC-1:0] take_x_o
);
  // Upward pass: "x below y" for the part of the lane up to this section.
  for (genvar i = 0; i < NSEC; i++) begin : g_up
    logic c;
    if (i == 0) begin : g_base
      assign c = lt_i[0];
    end else begin : g_link
      assign c = lt_i[i] | (eq_i[i] & ~mask_i[i-1] & g_up[i-1].c);
    end
  end

  // Downward pass: each section takes the decision of its lane's top section.
  for (genvar i = NSEC - 1; i >= 0; i--) begin : g_dn
    logic d;
    if (i == NSEC - 1) begin : g_top
      assign d = g_up[i].c;
    end else begin : g_spread
      assign d = mask_i[i] ? g_up[i].c : g_dn[i+1].d;
    end
    assign take_x_o[i] = d;
  end
endmodule

// File: rtl/pmin_lane_sel.sv
module pmin_lane_sel
  import pmin_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    x_i,
  input  logic [W-1:0]    y_i,
  input  logic [NSEC-1:0] take_x_i,
  output logic [W-1:0]    res_o
);
  localparam int SW = W / NSEC;
  for (genvar i = 0; i < NSEC; i++) begin : g_sel
    assign res_o[i*SW +: SW] = take_x_i[i] ? x_i[i*SW +: SW] : y_i[i*SW +: SW];
  end
endmodule

// File: rtl/pmin_unit.sv
module pmin_unit
  import pmin_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mask_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] min_o,
  output logic [W-1:0] min_q
);
  localparam int SW = W / NSEC;

  logic [NSEC-1:0] sec_lt;
  logic [NSEC-1:0] sec_eq;
  logic [NSEC-1:0] take_x;

  for (genvar i = 0; i < NSEC; i++) begin : g_cmp
    pmin_sec_cmp #(.SW(SW)) u_cmp (
      .xs_i (x_i[i*SW +: SW]),
      .ys_i (y_i[i*SW +: SW]),
      .lt_o (sec_lt[i]),
      .eq_o (sec_eq[i])
    );
  end

  pmin_chain u_chain (
    .lt_i     (sec_lt),
    .eq_i     (sec_eq),
    .mask_i   (mask_i),
    .take_x_o (take_x)
  );

  pmin_lane_sel #(.W(W)) u_sel (
    .x_i      (x_i),
    .y_i      (y_i),
    .take_x_i (take_x),
    .res_o    (min_o)
  );

  always_ff @(posedge clk) begin
    if (rst) min_q <= '0;
    else     min_q <= min_o;
  end
endmodule

// File: rtl/pmin_unit_chk.sv
module pmin_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   mask_i,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic [W-1:0] min_o,
  input logic [W-1:0] min_q
);
  localparam int SW = W / 4;

  assert_q_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (min_q == $past(min_o)));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (min_q == '0));

  assert_full_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (mask_i == 3'b000) |-> (min_o == ((x_i < y_i) ? x_i : y_i)));

  assert_equal_ops_R5: assert property (@(posedge clk) disable iff (rst)
    (x_i == y_i) |-> (min_o == x_i));

  for (genvar i = 0; i < 4; i++) begin : g_sec
    assert_no_move_R8: assert property (@(posedge clk) disable iff (rst)
      (min_o[i*SW +: SW] == x_i[i*SW +: SW]) || (min_o[i*SW +: SW] == y_i[i*SW +: SW]));
    assert_isolated_R2: assert property (@(posedge clk) disable iff (rst)
      (mask_i == 3'b111) |->
      (min_o[i*SW +: SW] <= x_i[i*SW +: SW]) && (min_o[i*SW +: SW] <= y_i[i*SW +: SW]));
  end
endmodule

bind pmin_unit pmin_unit_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mask_i (mask_i),
  .x_i    (x_i),
  .y_i    (y_i),
  .min_o  (min_o),
  .min_q  (min_q)
);

// File: tb/tb_pmin_unit.sv
`timescale 1ns/1ps
module tb_pmin_unit;
  localparam int W  = 32;
  localparam int SW = W / 4;
  localparam int NV = 6;

  localparam logic [2:0]   TM [NV] = '{3'b000, 3'b111, 3'b000, 3'b010, 3'b101, 3'b001};
  localparam logic [W-1:0] TX [NV] = '{32'h00000001, 32'h01FF0280, 32'h01FF0280,
                                       32'h01FF0280, 32'h10203040, 32'hAABBCC05};
  localparam logic [W-1:0] TY [NV] = '{32'h00000002, 32'h02000103, 32'h02000103,
                                       32'h02000103, 32'h1030203F, 32'hAABBCB09};
  localparam logic [W-1:0] TE [NV] = '{32'h00000001, 32'h01000103, 32'h01FF0280,
                                       32'h01FF0103, 32'h1020303F, 32'hAABBCB05};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   mask_i = '0;
  logic [W-1:0] x_i = '0;
  logic [W-1:0] y_i = '0;
  logic [W-1:0] min_o;
  logic [W-1:0] min_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pmin_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .mask_i(mask_i), .x_i(x_i), .y_i(y_i),
    .min_o(min_o), .min_q(min_q)
  );

  function automatic logic [W-1:0] ref_min(input logic [2:0] m,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    logic [W-1:0] r;
    int start;
    r = '0;
    start = 0;
    for (int s = 0; s < 4; s++) begin
      if (s == 3 || m[s]) begin
        longint unsigned la, lb, msk;
        int lo, len;
        lo  = start * SW;
        len = (s + 1 - start) * SW;
        msk = (64'd1 << len) - 64'd1;
        la  = (longint'(a) >> lo) & msk;
        lb  = (longint'(b) >> lo) & msk;
        for (int k = 0; k < len; k++)
          r[lo + k] = (la < lb) ? la[k] : lb[k];
        start = s + 1;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (mask %b x %h y %h)", req, act, exp, mask_i, x_i, y_i);
    end
  endtask

  // Apply mask and operands together, check comb output, then the register.
  task automatic apply(input string req, input logic [2:0] m,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] exp);
    @(negedge clk);
    mask_i = m; x_i = a; y_i = b;
    #2;
    check({req, " R6 comb"}, min_o, exp);
    @(posedge clk);
    #1;
    check({req, " R7 reg"}, min_q, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R7: reset clears the register even with nonzero operands present
    x_i = 32'h12345678; y_i = 32'h87654321;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", min_q, '0);
    @(negedge clk);
    rst = 1'b0;

    // Directed table: R1 boundary placement, R2 isolation, R3 cascade, R4 uneven
    for (int v = 0; v < NV; v++)
      apply("R1 R2 R3 R4 table", TM[v], TX[v], TY[v], TE[v]);

    // Sweep of all masks, mask and data changing in the same cycle
    for (int m = 0; m < 8; m++) begin
      logic [2:0] mm;
      mm = 3'(m);
      apply("R4 zero", mm, '0, 32'hFFFFFFFF, '0);
      apply("R4 ones", mm, 32'hFFFFFFFF, '0, '0);
      apply("R5 equal", mm, 32'h5A5A5A5A, 32'h5A5A5A5A, 32'h5A5A5A5A);
      for (int r = 0; r < 16; r++) begin
        logic [W-1:0] a, b;
        a = $urandom;
        b = $urandom;
        if (r % 4 == 0) b[W-1 -: SW] = a[W-1 -: SW];  // top equal: R3 fall-through
        if (r % 4 == 1) b[SW-1:0] = a[SW-1:0];
        apply("R3 R8 random", mm, a, b, ref_min(mm, a, b));
      end
    end

    // R5: equal lane values in one lane, differing in another
    apply("R5 partial equal", 3'b011, 32'hABCD0011, 32'hABCD0022, 32'hABCD0011);

    // R7: reset again mid-run clears the register
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R7 mid reset", min_q, '0);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    finish_run();
  end
endmodule